// File: doc/BRIEF.md
# Serial Control Port with Interface Latches

This block is the control access point of a mixed-signal line device. A host writes and reads the device's settings over a three-wire serial link. The link has an active-low select, a data-in line and a data-out line. A control clock of its own times the link, and that clock carries no phase relation to any other clock on the chip. The whole block runs from that clock: it samples input on the falling edge and launches output on the rising edge.

Each framed access begins with an instruction byte, which is always shifted into the device. Bit 2 of the instruction chooses the direction of the second byte: 1 shifts it out to the host and 0 writes it into the device. Bits 1:0 address one of three registers:

- a byte-wide control register;
- a direction register for the four interface pins;
- the interface latch register.

The latch register drives the pins set as outputs. On the pins set as inputs, it samples the pin levels each time control data is written. The pad ring builds the tri-state pins and data-out line from the separate value and enable outputs.

Top module: `ctlp_serial_port`

## Requirements
- R1: While `rst_ni` is low and after it rises, the control register holds `CTRL_RST` (default 0x00), and the direction and latch registers hold 0. This means every pin is an input (`io_oe_o` = 0) and `sdo_oe_o` is low.
- R2: Data moves only while `cs_ni` is low, MSB first, with `sdi_i` sampled on falling edges of `sclk_i`. The first byte is the instruction: bit 2 = 1 means read and 0 means write, bits 1:0 select the register (0 control, 1 direction, 2 latch, 3 none), and bits 7:3 are ignored.
- R3: In a write access, the addressed register takes the second byte at its eighth falling edge. The direction and latch registers use bits 3:0. A write to address 3 changes nothing.
- R4: In a read access, `sdo_oe_o` rises at the first rising edge after the instruction byte and stays high for exactly eight rising edges. `sdo_o` presents the register MSB first and changes on rising edges. Direction and latch reads return zeros in bits 7:4, and address 3 reads as 0x00.
- R5: `sdo_oe_o` is low during every instruction byte, during every write access and while `cs_ni` is high, and `sdo_o` is 0 whenever `sdo_oe_o` is low.
- R6: `io_oe_o` equals the direction register and `io_o` equals the latch register at all times.
- R7: At the end of every complete instruction byte, each latch bit whose direction bit is 0 takes the level on `io_i`. A latch write sets the direction-1 bits from the data and the direction-0 bits from `io_i`.
- R8: Raising `cs_ni` before a byte is complete aborts it: no register changes and no input capture happens, and the next access starts with a fresh instruction byte.
- R9: Bits shifted after the second byte, until `cs_ni` rises, are ignored and leave `sdo_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Control clock; input sampled on falling edge, output launched on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select; framing and abort |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value (0 when not driven) |
| sdo_oe_o | output | 1 | Drive enable for serial data out |
| io_i | input | NUM_IO | Levels sensed on the interface pins |
| io_o | output | NUM_IO | Interface pin output values (latch register) |
| io_oe_o | output | NUM_IO | Interface pin drive enables (direction register) |

## Verification
The bound checker watches four properties on every clock edge:

- the quiet state during reset;
- that `sdo_oe_o` is never high without select;
- that a read drive window never lasts beyond eight rising edges;
- that the pin values and enables never move while select stays high.

Three behaviours need the bench's scenarios, because each one depends on a full access and on the bit values the host sent. These are the bit order of read data, the mixing of captured pin levels with written latch bits under every direction pattern, and the discarding of aborted or surplus bytes.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int RD_BIT = 2;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;
  typedef enum logic [1:0] {A_CTRL = 2'd0, A_DIR = 2'd1, A_LATCH = 2'd2, A_NONE = 2'd3} addr_e;
endpackage

// File: rtl/ctlp_rx.sv
module ctlp_rx
  import ctlp_pkg::*;
(
  input  logic                sclk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sdi_i,
  output phase_e              phase_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [RD_BIT:0]     instr_o,
  output logic                byte_done_o,
  output logic [BYTE_W-1:0]   byte_o
);
  logic [BYTE_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  phase_e            phase_q;
  logic [RD_BIT:0]   instr_q;

  assign byte_o      = {sr_q, sdi_i};
  assign byte_done_o = !cs_ni && (cnt_q == CNT_W'(BYTE_W-1)) && (phase_q != PH_DONE);

  // select high clears framing asynchronously: abort and idle share one path
  always_ff @(negedge sclk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      phase_q <= PH_INSTR;
      instr_q <= '0;
    end else if (cs_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      phase_q <= PH_INSTR;
    end else begin
      sr_q  <= byte_o[BYTE_W-2:0];
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(BYTE_W-1)) begin
        case (phase_q)
          PH_INSTR: begin
            phase_q <= PH_DATA;
            instr_q <= byte_o[RD_BIT:0];
          end
          PH_DATA: phase_q <= PH_DONE;
          default: phase_q <= PH_DONE;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign instr_o = instr_q;
endmodule

// File: rtl/ctlp_regs.sv
module ctlp_regs
  import ctlp_pkg::*;
#(
  parameter int                NUM_IO   = 4,
  parameter logic [BYTE_W-1:0] CTRL_RST = '0
) (
  input  logic                sclk_i,
  input  logic                rst_ni,
  input  phase_e              phase_i,
  input  logic [RD_BIT:0]     instr_i,
  input  logic                byte_done_i,
  input  logic [BYTE_W-1:0]   byte_i,
  input  logic [NUM_IO-1:0]   io_i,
  output logic [BYTE_W-1:0]   ctrl_o,
  output logic [NUM_IO-1:0]   dir_o,
  output logic [NUM_IO-1:0]   latch_o
);
  logic [BYTE_W-1:0] ctrl_q;
  logic [NUM_IO-1:0] dir_q, latch_q, cap_val, wr_val;
  addr_e             addr;

  assign addr = addr_e'(instr_i[1:0]);

  for (genvar i = 0; i < NUM_IO; i++) begin : g_bit
    assign cap_val[i] = dir_q[i] ? latch_q[i] : io_i[i];
    assign wr_val[i]  = dir_q[i] ? byte_i[i]  : io_i[i];
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= CTRL_RST;
      dir_q   <= '0;
      latch_q <= '0;
    end else if (byte_done_i) begin
      if (phase_i == PH_INSTR) begin
        latch_q <= cap_val;
      end else if (!instr_i[RD_BIT]) begin
        case (addr)
          A_CTRL:  ctrl_q  <= byte_i;
          A_DIR:   dir_q   <= byte_i[NUM_IO-1:0];
          A_LATCH: latch_q <= wr_val;
          default: ;
        endcase
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign dir_o   = dir_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/ctlp_tx.sv
module ctlp_tx
  import ctlp_pkg::*;
#(
  parameter int NUM_IO = 4
) (
  input  logic               sclk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  phase_e             phase_i,
  input  logic [RD_BIT:0]    instr_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [BYTE_W-1:0]  ctrl_i,
  input  logic [NUM_IO-1:0]  dir_i,
  input  logic [NUM_IO-1:0]  latch_i,
  output logic               sdo_o,
  output logic               sdo_oe_o
);
  logic [BYTE_W-1:0] rd_word;
  logic              sdo_q, oe_q;

  always_comb begin
    rd_word = '0;
    case (addr_e'(instr_i[1:0]))
      A_CTRL:  rd_word = ctrl_i;
      A_DIR:   rd_word[NUM_IO-1:0] = dir_i;
      A_LATCH: rd_word[NUM_IO-1:0] = latch_i;
      default: rd_word = '0;
    endcase
  end

  // registers are quiet during a read, so bits are picked live
  always_ff @(posedge sclk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (cs_ni) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (phase_i == PH_DATA) && instr_i[RD_BIT];
      sdo_q <= rd_word[CNT_W'(BYTE_W-1) - cnt_i];
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = oe_q & sdo_q;
endmodule

// File: rtl/ctlp_serial_port.sv
module ctlp_serial_port
  import ctlp_pkg::*;
#(
  parameter int                NUM_IO   = 4,
  parameter logic [BYTE_W-1:0] CTRL_RST = '0
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic [NUM_IO-1:0] io_i,
  output logic [NUM_IO-1:0] io_o,
  output logic [NUM_IO-1:0] io_oe_o
);
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [RD_BIT:0]   instr;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte, ctrl;
  logic [NUM_IO-1:0] dir, latch;

  ctlp_rx u_rx (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdi_i(sdi_i),
    .phase_o(phase), .cnt_o(cnt), .instr_o(instr),
    .byte_done_o(byte_done), .byte_o(rx_byte)
  );

  ctlp_regs #(.NUM_IO(NUM_IO), .CTRL_RST(CTRL_RST)) u_regs (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .phase_i(phase), .instr_i(instr),
    .byte_done_i(byte_done), .byte_i(rx_byte), .io_i(io_i),
    .ctrl_o(ctrl), .dir_o(dir), .latch_o(latch)
  );

  ctlp_tx #(.NUM_IO(NUM_IO)) u_tx (
    .sclk_i(sclk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .phase_i(phase),
    .instr_i(instr), .cnt_i(cnt), .ctrl_i(ctrl), .dir_i(dir),
    .latch_i(latch), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  assign io_o    = latch;
  assign io_oe_o = dir;
endmodule

// File: rtl/ctlp_checker.sv
module ctlp_checker #(
  parameter int NUM_IO = 4
) (
  input logic              sclk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              sdo_oe_o,
  input logic [NUM_IO-1:0] io_o,
  input logic [NUM_IO-1:0] io_oe_o
);
  logic [3:0] rd_run;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) rd_run <= '0;
    else if (sdo_oe_o) rd_run <= (rd_run == 4'd15) ? rd_run : rd_run + 4'd1;
    else rd_run <= '0;
  end

  a_r1_reset_quiet: assert property (@(posedge sclk_i)
    !rst_ni |-> (io_oe_o == '0 && !sdo_oe_o));

  a_r5_oe_needs_select: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !cs_ni);

  a_r4_read_window: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    rd_run <= 4'd8);

  a_r8_idle_hold: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> ($stable(io_o) && $stable(io_oe_o)));
endmodule

bind ctlp_serial_port ctlp_checker #(.NUM_IO(NUM_IO)) u_chk (
  .sclk_i(sclk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sdo_oe_o(sdo_oe_o),
  .io_o(io_o), .io_oe_o(io_oe_o)
);

// File: tb/tb_ctlp_serial_port.sv
`timescale 1ns/1ps
module tb_ctlp_serial_port;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         cs_n = 1'b1;
  logic         sdi = 1'b0;
  logic [N-1:0] io_in = '0;
  logic         sdo, sdo_oe;
  logic [N-1:0] io_out, io_oe;

  int vecs = 0;
  int errs = 0;

  logic [7:0]   m_ctrl;
  logic [N-1:0] m_dir, m_latch;

  ctlp_serial_port #(.NUM_IO(N), .CTRL_RST(8'h00)) dut (
    .sclk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // n1 instruction bits, n2 second-stage bits (bits past 8 carry ~dat)
  task automatic txn(input logic [7:0] ins, input logic [7:0] dat, input int n1,
                     input int n2, input logic [N-1:0] pins, output logic [7:0] rd);
    rd = '0;
    io_in = pins;
    for (int i = 0; i < n1; i++) begin
      @(posedge clk); #1;
      cs_n = 1'b0; sdi = ins[7-i];
      #1 chk(!sdo_oe, "R5 oe in instr", sdo_oe, 0);
    end
    if (n1 == 8) begin
      for (int i = 0; i < n2; i++) begin
        @(posedge clk); #1;
        sdi = (i < 8) ? dat[7-i] : ~dat[15-i];
        #1;
        if (i < 8) begin
          rd[7-i] = sdo;
          chk(sdo_oe == ins[2], ins[2] ? "R4 oe in read" : "R5 oe in write", sdo_oe, ins[2]);
        end else begin
          chk(!sdo_oe, "R9 oe after 2nd byte", sdo_oe, 0);
        end
      end
    end
    @(posedge clk); #1 cs_n = 1'b1;
    #1 chk(!sdo_oe && !sdo, "R5 oe with cs high", sdo_oe, 0);
    @(posedge clk); @(posedge clk);
    if (n1 == 8) begin
      m_latch = (m_latch & m_dir) | (pins & ~m_dir);
      if (n2 >= 8 && !ins[2]) begin
        case (ins[1:0])
          2'd0: m_ctrl = dat;
          2'd1: m_dir = dat[N-1:0];
          2'd2: m_latch = (dat[N-1:0] & m_dir) | (pins & ~m_dir);
          default: ;
        endcase
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [N-1:0] p);
    logic [7:0] r;
    txn({5'b10110, 1'b0, a}, d, 8, 8, p, r);
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [N-1:0] p, input string req);
    logic [7:0] r, e;
    txn({5'b01001, 1'b1, a}, 8'h00, 8, 8, p, r);
    case (a)
      2'd0: e = m_ctrl;
      2'd1: e = {4'h0, m_dir};
      2'd2: e = {4'h0, m_latch};
      default: e = 8'h00;
    endcase
    chk(r == e, req, r, e);
  endtask

  initial begin
    #(200000 * 10);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] r;
    m_ctrl = 8'h00; m_dir = '0; m_latch = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk(io_oe == 0 && io_out == 0 && !sdo_oe, "R1 reset outputs", {io_oe, io_out}, 0);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    rd_chk(2'd0, 4'h0, "R1 ctrl default");
    rd_chk(2'd1, 4'h0, "R1 dir default");

    // R2 R3 R4: control register patterns, MSB first
    foreach (r[i]) ;
    wr(2'd0, 8'hA5, 4'h0); rd_chk(2'd0, 4'h0, "R4 ctrl A5");
    wr(2'd0, 8'h3C, 4'h0); rd_chk(2'd0, 4'h0, "R4 ctrl 3C");
    wr(2'd0, 8'h81, 4'h0); rd_chk(2'd0, 4'h0, "R2 ctrl 81 msb first");
    wr(2'd0, 8'hFF, 4'h0); rd_chk(2'd0, 4'h0, "R3 ctrl FF");

    // R3: address 3 writes nothing, reads zero
    wr(2'd3, 8'h5A, 4'h0);
    rd_chk(2'd0, 4'h0, "R3 addr3 write no effect");
    rd_chk(2'd3, 4'h0, "R4 addr3 reads zero");

    // R6 R7: sweep direction x latch data, pins varied
    for (int d = 0; d < 16; d++) begin
      for (int v = 0; v < 16; v++) begin
        wr(2'd1, {4'hF, 4'(d)}, 4'(v ^ 9));
        chk(io_oe == 4'(d), "R6 io_oe_o follows dir", io_oe, d);
        wr(2'd2, {4'hA, 4'(v)}, 4'(~v));
        chk(io_out == m_latch, "R7 latch write mix", io_out, m_latch);
        rd_chk(2'd2, 4'(v + d), "R7 capture on instr");
        chk(io_out == m_latch, "R6 io_o follows latch", io_out, m_latch);
      end
    end

    // R8: aborts
    wr(2'd0, 8'h66, 4'h0);
    txn(8'h00, 8'h99, 8, 5, 4'h0, r);
    rd_chk(2'd0, 4'h0, "R8 abort in data byte");
    wr(2'd1, 8'h00, 4'h0);
    txn(8'h00, 8'h00, 4, 0, 4'hF, r);
    chk(io_out == m_latch, "R8 abort in instr no capture", io_out, m_latch);
    wr(2'd0, 8'h24, 4'h0);
    rd_chk(2'd0, 4'h0, "R8 fresh access after abort");

    // R9: surplus bits ignored
    txn(8'h00, 8'hC3, 8, 16, 4'h0, r);
    rd_chk(2'd0, 4'h0, "R9 surplus byte ignored");
    txn(8'h04, 8'h00, 8, 16, 4'h0, r);
    chk(r == m_ctrl, "R9 read with surplus", r, m_ctrl);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule